// File: doc/BRIEF.md
# Single-Cycle 32-bit Load-Store Processor

This block is a 32-bit processor core that completes one instruction in every clock cycle. It fetches a fixed-width instruction from a private instruction memory and decodes it in one of three formats: register, immediate or jump. It reads two operands from a 32-entry register file. In the same cycle it writes the result, or performs a word access to a private data memory. It then updates the program counter from one of four sources: the next instruction, a PC-relative branch, a jump within the current 256 MB region, or a register value.

Arithmetic only ever works on register operands. Memory is reached only through the word load and word store instructions. The data path is 32 bits wide and the byte addresses are word aligned. During bring-up, both memories are filled through two simple write ports while reset is held. A debug port returns any register combinationally, so the result of a program can be observed from outside.

Top module: `sc_cpu32`

## Requirements
- R1: While the synchronous reset `rst` is high, the PC is held at 0 and every register reads 0. After reset is released, the first instruction is fetched from byte address 0.
- R2: Register 0 always reads as zero. Any write that targets it is dropped.
- R3: A register-format instruction has opcode 0 in bits [31:26], rs in [25:21], rt in [20:16], rd in [15:11] and funct in [5:0]. Funct 32 gives rd = rs + rt and funct 34 gives rd = rs - rt. Both wrap modulo 2^32.
- R4: Funct 42 writes 1 to rd when rs is less than rt as signed 32-bit values, and writes 0 otherwise.
- R5: An immediate-format instruction carries its 16-bit constant in bits [15:0] and its result goes to rt. Opcode 8 adds the sign-extended constant to rs. Opcode 13 ORs rs with the zero-extended constant. Opcode 15 writes the constant to the upper half of rt and zeros to the lower half.
- R6: The effective address is rs plus the sign-extended constant, and its bits above [1:0] select the word. Opcode 35 loads that word into rt. Opcode 43 stores rt into that word.
- R7: Opcode 4 branches when rs equals rt, and opcode 5 branches when they differ. The target is PC+4 plus the sign-extended constant shifted left by 2. A branch that is not taken goes on to PC+4.
- R8: Opcode 2 jumps to {PC+4[31:28], bits [25:0] of the instruction, 2'b00}.
- R9: Opcode 3 jumps in the same way as R8 and also writes PC+4 into register 31.
- R10: Register-format funct 8 loads the PC from rs with its two low bits cleared.
- R11: Any other opcode, or any other register-format funct, changes no register and no memory word, and execution continues at PC+4.
- R12: The instruction and data preload ports write one word per clock cycle at the given word index. Programs can read words preloaded into data memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_wr_en | input | 1 | Instruction memory preload write enable |
| imem_wr_addr | input | IMEM_AW (8) | Instruction memory preload word index |
| imem_wr_data | input | 32 | Instruction memory preload word |
| dmem_wr_en | input | 1 | Data memory preload write enable |
| dmem_wr_addr | input | DMEM_AW (8) | Data memory preload word index |
| dmem_wr_data | input | 32 | Data memory preload word |
| dbg_sel | input | 5 | Register index for the debug read |
| dbg_data | output | 32 | Contents of the selected register |

## Verification
The assertions check the following on every cycle:
- register 0 stays zero;
- the PC stays word aligned;
- the PC is 0 just after reset;
- a call leaves PC+4 in register 31;
- a jump keeps the PC's region bits;
- an untaken branch or an unknown opcode advances the PC by exactly 4.

The arithmetic results, the signed comparison, constant building, store-then-load, taken branches with negative offsets, jump-register low-bit clearing and preloaded data are visible only as register values after the bench's programs finish. The bench therefore reads those values through the debug port and compares them with values it computes itself.

// File: rtl/sc_cpu32.sv
module sc_cpu32 #(
  parameter int IMEM_WORDS = 256,
  parameter int DMEM_WORDS = 256,
  localparam int IMEM_AW = $clog2(IMEM_WORDS),
  localparam int DMEM_AW = $clog2(DMEM_WORDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               imem_wr_en,
  input  logic [IMEM_AW-1:0] imem_wr_addr,
  input  logic [31:0]        imem_wr_data,
  input  logic               dmem_wr_en,
  input  logic [DMEM_AW-1:0] dmem_wr_addr,
  input  logic [31:0]        dmem_wr_data,
  input  logic [4:0]         dbg_sel,
  output logic [31:0]        dbg_data
);

  logic [31:0] imem [IMEM_WORDS];
  logic [31:0] dmem [DMEM_WORDS];
  logic [31:0] rf [32];
  logic [31:0] pc;

  logic [31:0] instr;
  logic [5:0]  op, funct;
  logic [4:0]  rs, rt, rd;
  logic [15:0] imm16;
  logic [31:0] rs_val, rt_val, imm_s, imm_z;
  logic [31:0] pc_plus4, br_tgt, jmp_tgt, mem_addr, ld_val;

  logic        wr_en, st_en;
  logic [4:0]  wr_idx;
  logic [31:0] wr_val, next_pc;

  assign instr    = imem[pc[IMEM_AW+1:2]];
  assign op       = instr[31:26];
  assign rs       = instr[25:21];
  assign rt       = instr[20:16];
  assign rd       = instr[15:11];
  assign funct    = instr[5:0];
  assign imm16    = instr[15:0];

  assign rs_val   = rf[rs];
  assign rt_val   = rf[rt];
  assign imm_s    = {{16{imm16[15]}}, imm16};
  assign imm_z    = {16'h0000, imm16};

  assign pc_plus4 = pc + 32'd4;
  assign br_tgt   = pc_plus4 + {imm_s[29:0], 2'b00};
  assign jmp_tgt  = {pc_plus4[31:28], instr[25:0], 2'b00};
  assign mem_addr = rs_val + imm_s;
  assign ld_val   = dmem[mem_addr[DMEM_AW+1:2]];
  assign dbg_data = rf[dbg_sel];

  logic unused_bits;
  assign unused_bits = ^{pc[31:IMEM_AW+2], pc[1:0], instr[10:6],
                         mem_addr[31:DMEM_AW+2], mem_addr[1:0]};

  always_comb begin
    wr_en   = 1'b0;
    wr_idx  = rt;
    wr_val  = '0;
    st_en   = 1'b0;
    next_pc = pc_plus4;
    case (op)
      6'd0: begin
        wr_idx = rd;
        case (funct)
          6'd32: begin wr_en = 1'b1; wr_val = rs_val + rt_val; end
          6'd34: begin wr_en = 1'b1; wr_val = rs_val - rt_val; end
          6'd42: begin
            wr_en  = 1'b1;
            wr_val = {31'd0, $signed(rs_val) < $signed(rt_val)};
          end
          6'd8:    next_pc = {rs_val[31:2], 2'b00};
          default: ;
        endcase
      end
      6'd8:  begin wr_en = 1'b1; wr_val = rs_val + imm_s; end
      6'd13: begin wr_en = 1'b1; wr_val = rs_val | imm_z; end
      6'd15: begin wr_en = 1'b1; wr_val = {imm16, 16'h0000}; end
      6'd35: begin wr_en = 1'b1; wr_val = ld_val; end
      6'd43: st_en = 1'b1;
      6'd4:  if (rs_val == rt_val) next_pc = br_tgt;
      6'd5:  if (rs_val != rt_val) next_pc = br_tgt;
      6'd2:  next_pc = jmp_tgt;
      6'd3: begin
        next_pc = jmp_tgt;
        wr_en   = 1'b1;
        wr_idx  = 5'd31;
        wr_val  = pc_plus4;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= next_pc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 32; i++) rf[i] <= '0;
    end else if (wr_en && wr_idx != 5'd0) begin
      rf[wr_idx] <= wr_val;
    end
  end

  always_ff @(posedge clk) begin
    if (imem_wr_en) imem[imem_wr_addr] <= imem_wr_data;
  end

  always_ff @(posedge clk) begin
    if (dmem_wr_en)          dmem[dmem_wr_addr] <= dmem_wr_data;
    else if (!rst && st_en)  dmem[mem_addr[DMEM_AW+1:2]] <= rt_val;
  end

  a_r1_pc_zero_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> pc == 32'd0);

  a_r2_zero_reg_stays_zero: assert property (@(posedge clk) disable iff (rst)
    rf[0] == 32'd0);

  a_r10_pc_word_aligned: assert property (@(posedge clk) disable iff (rst)
    pc[1:0] == 2'b00);

  a_r7_untaken_falls_through: assert property (@(posedge clk) disable iff (rst)
    (op == 6'd4 && rs_val != rt_val) || (op == 6'd5 && rs_val == rt_val)
    |=> pc == $past(pc) + 32'd4);

  a_r8_jump_keeps_region: assert property (@(posedge clk) disable iff (rst)
    (op == 6'd2 || op == 6'd3) |=> pc[31:28] == $past(pc_plus4[31:28]));

  a_r9_link_written: assert property (@(posedge clk) disable iff (rst)
    op == 6'd3 |=> rf[31] == $past(pc) + 32'd4);

  a_r11_unknown_op_advances: assert property (@(posedge clk) disable iff (rst)
    op == 6'd63 |=> pc == $past(pc) + 32'd4);

endmodule

// File: tb/sc_cpu32_tb_top.sv
module sc_cpu32_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        imem_wr_en = 1'b0;
  logic [7:0]  imem_wr_addr = '0;
  logic [31:0] imem_wr_data = '0;
  logic        dmem_wr_en = 1'b0;
  logic [7:0]  dmem_wr_addr = '0;
  logic [31:0] dmem_wr_data = '0;
  logic [4:0]  dbg_sel = '0;
  logic [31:0] dbg_data;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [31:0] prog [32];
  int          plen;

  always #(CLK_PERIOD/2) clk = ~clk;

  sc_cpu32 dut_i (
    .clk(clk), .rst(rst),
    .imem_wr_en(imem_wr_en), .imem_wr_addr(imem_wr_addr), .imem_wr_data(imem_wr_data),
    .dmem_wr_en(dmem_wr_en), .dmem_wr_addr(dmem_wr_addr), .dmem_wr_data(dmem_wr_data),
    .dbg_sel(dbg_sel), .dbg_data(dbg_data)
  );

  function automatic logic [31:0] enc_r(input logic [4:0] s, input logic [4:0] t,
                                        input logic [4:0] d, input logic [5:0] f);
    return {6'd0, s, t, d, 5'd0, f};
  endfunction

  function automatic logic [31:0] enc_i(input logic [5:0] o, input logic [4:0] s,
                                        input logic [4:0] t, input logic [15:0] k);
    return {o, s, t, k};
  endfunction

  function automatic logic [31:0] enc_j(input logic [5:0] o, input logic [25:0] a);
    return {o, a};
  endfunction

  function automatic logic [31:0] exp_lt(input logic [31:0] x, input logic [31:0] y);
    return ($signed(x) < $signed(y)) ? 32'd1 : 32'd0;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic read_reg(input int idx, output logic [31:0] v);
    dbg_sel = idx[4:0];
    #1;
    v = dbg_data;
  endtask

  task automatic load_and_run(input int cycles);
    logic [31:0] v;
    rst = 1'b1;
    @(negedge clk);
    for (int i = 0; i < plen; i++) begin
      imem_wr_en   = 1'b1;
      imem_wr_addr = i[7:0];
      imem_wr_data = prog[i];
      @(negedge clk);
    end
    imem_wr_en = 1'b0;
    for (int r = 1; r < 32; r += 10) begin
      read_reg(r, v);
      check($sformatf("R1 reg %0d cleared in reset", r), v, 32'd0);
    end
    rst = 1'b0;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic run_arith(input logic [31:0] a, input logic [31:0] b, input logic [15:0] k);
    logic [31:0] v;
    prog[0]  = enc_i(6'd15, 5'd0, 5'd1, a[31:16]);
    prog[1]  = enc_i(6'd13, 5'd1, 5'd1, a[15:0]);
    prog[2]  = enc_i(6'd15, 5'd0, 5'd2, b[31:16]);
    prog[3]  = enc_i(6'd13, 5'd2, 5'd2, b[15:0]);
    prog[4]  = enc_r(5'd1, 5'd2, 5'd3, 6'd32);
    prog[5]  = enc_r(5'd1, 5'd2, 5'd4, 6'd34);
    prog[6]  = enc_r(5'd1, 5'd2, 5'd5, 6'd42);
    prog[7]  = enc_i(6'd8, 5'd1, 5'd6, k);
    prog[8]  = enc_i(6'd13, 5'd2, 5'd7, k);
    prog[9]  = enc_r(5'd2, 5'd1, 5'd8, 6'd42);
    prog[10] = enc_r(5'd1, 5'd2, 5'd0, 6'd32);
    prog[11] = enc_i(6'd63, 5'd1, 5'd10, 16'hFFFF);
    prog[12] = enc_r(5'd1, 5'd2, 5'd11, 6'd63);
    prog[13] = enc_i(6'd4, 5'd0, 5'd0, 16'hFFFF);
    plen = 14;
    load_and_run(30);
    read_reg(1, v);  check("R5 lui/ori build r1", v, a);
    read_reg(2, v);  check("R5 lui/ori build r2", v, b);
    read_reg(3, v);  check("R3 add", v, a + b);
    read_reg(4, v);  check("R3 sub", v, a - b);
    read_reg(5, v);  check("R4 slt a<b", v, exp_lt(a, b));
    read_reg(8, v);  check("R4 slt b<a", v, exp_lt(b, a));
    read_reg(6, v);  check("R5 addi sign-extended", v, a + {{16{k[15]}}, k});
    read_reg(7, v);  check("R5 ori zero-extended", v, b | {16'h0, k});
    read_reg(0, v);  check("R2 write to r0 dropped", v, 32'd0);
    read_reg(10, v); check("R11 unknown opcode no write", v, 32'd0);
    read_reg(11, v); check("R11 unknown funct no write", v, 32'd0);
  endtask

  task automatic run_control;
    logic [31:0] v;
    @(negedge clk);
    dmem_wr_en   = 1'b1;
    dmem_wr_addr = 8'd20;
    dmem_wr_data = 32'hCAFEBABE;
    @(negedge clk);
    dmem_wr_en = 1'b0;
    prog[0]  = enc_i(6'd8, 5'd0, 5'd1, 16'd5);
    prog[1]  = enc_i(6'd8, 5'd0, 5'd2, 16'd5);
    prog[2]  = enc_i(6'd4, 5'd1, 5'd2, 16'd1);
    prog[3]  = enc_i(6'd8, 5'd0, 5'd3, 16'd1);
    prog[4]  = enc_i(6'd5, 5'd1, 5'd2, 16'd1);
    prog[5]  = enc_i(6'd8, 5'd0, 5'd4, 16'd7);
    prog[6]  = enc_i(6'd5, 5'd1, 5'd0, 16'd1);
    prog[7]  = enc_i(6'd8, 5'd0, 5'd3, 16'd2);
    prog[8]  = enc_i(6'd4, 5'd4, 5'd1, 16'd1);
    prog[9]  = enc_i(6'd8, 5'd0, 5'd5, 16'h0040);
    prog[10] = enc_i(6'd43, 5'd5, 5'd4, 16'hFFFC);
    prog[11] = enc_i(6'd35, 5'd0, 5'd6, 16'h003C);
    prog[12] = enc_j(6'd3, 26'd16);
    prog[13] = enc_i(6'd35, 5'd0, 5'd10, 16'd80);
    prog[14] = enc_i(6'd4, 5'd0, 5'd0, 16'hFFFF);
    prog[15] = enc_i(6'd8, 5'd0, 5'd12, 16'd99);
    prog[16] = enc_j(6'd2, 26'd17);
    prog[17] = enc_i(6'd8, 5'd0, 5'd8, 16'd3);
    prog[18] = enc_i(6'd8, 5'd0, 5'd9, 16'd53);
    prog[19] = enc_r(5'd9, 5'd0, 5'd0, 6'd8);
    plen = 20;
    load_and_run(40);
    read_reg(3, v);  check("R7 taken beq/bne skip their shadows", v, 32'd0);
    read_reg(4, v);  check("R7 untaken bne falls through", v, 32'd7);
    read_reg(5, v);  check("R7 untaken beq falls through", v, 32'h40);
    read_reg(6, v);  check("R6 store then load negative offset", v, 32'd7);
    read_reg(31, v); check("R9 link holds return address", v, 32'd52);
    read_reg(8, v);  check("R8 jump reached target", v, 32'd3);
    read_reg(12, v); check("R7 negative-offset loop never falls through", v, 32'd0);
    read_reg(9, v);  check("R10 jr source untouched", v, 32'd53);
    read_reg(10, v); check("R12 preloaded data word via R10 return", v, 32'hCAFEBABE);
  endtask

  initial begin
    logic [31:0] a, b, k;
    void'($urandom(32'd20240611));
    run_arith(32'h7FFFFFFF, 32'h80000000, 16'h8000);
    run_arith(32'h12345678, 32'h12345678, 16'h7FFF);
    run_arith(32'hFFFFFFFF, 32'h00000001, 16'hFFFF);
    run_control();
    for (int it = 0; it < 16; it++) begin
      a = $urandom();
      b = $urandom();
      k = $urandom();
      run_arith(a, b, k[15:0]);
    end
    run_control();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule